// File: doc/BRIEF.md
# Two-Wire Control Slave for a Stereo Volume and Balance Processor

This block is a write-only two-wire serial slave that owns the control registers of a two-input stereo audio processor. It oversamples the clock and data lines with the system clock, finds the start and stop framing, matches its fixed device address and shifts each byte in with the most significant bit first. After every byte it accepts, it pulls the data line low for the ninth clock.

The first byte after the address is a subaddress. Its low nibble picks a register slot and bit 4 picks the addressing mode. Either every following data byte lands in the same slot, or the slot advances after each byte. The register fields drive the source multiplexer, the input gain, the master volume and the right and left speaker attenuators. The block also provides a registered mute flag for each attenuator. After reset every attenuator is muted.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: After reset the outputs are: source select 2'b10 (second input), input gain 4'hE (28 dB), volume code 7'h7F, both speaker codes 7'h7F, and all three mute flags 1.
- R2: A START (data falls while clock is high) followed by the write address byte 8'h88 (7-bit address 7'h44, direction bit 0) is acknowledged: sda_pull_low is 1 while the ninth clock is high. Every later accepted byte is acknowledged the same way, and no register changes without an acknowledge.
- R3: An address byte other than 8'h88, including the read address 8'h89, gets no acknowledge. Every byte after it up to the next START is ignored: no acknowledge and no register change.
- R4: In the subaddress byte, bits [3:0] are the slot index, bit 4 is the increment flag, and bits [7:5] have no effect.
- R5: With the increment flag at 0, every data byte up to STOP is written to the same slot, so the last one wins.
- R6: With the increment flag at 1, each data byte after the first goes to the previous slot plus one, and the index wraps from 15 to 0. Bytes aimed at slots 8 to 15 are acknowledged and change nothing.
- R7: Slots 3, 4 and 5 accept bytes (with an acknowledge) and change no output.
- R8: Slot 0 drives the source select from data bits [1:0]. 2'b11 selects the first input and 2'b10 the second. 2'b00 and 2'b01 leave the previous selection unchanged.
- R9: Slot 1 takes data bits [3:0] as the gain code in 2 dB steps. Slots 2, 6 and 7 take data bits [6:0] as the volume, right speaker and left speaker codes. Bit 7 is ignored.
- R10: The volume mute flag is 1 exactly when volume code bits [6:3] are 6 or more. Each speaker mute flag is 1 exactly when that code's bits [6:3] are 10 or more.
- R11: A repeated START in the middle of a transfer abandons it and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the wire |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| src_sel | output | 2 | Source select code (2'b11 first input, 2'b10 second) |
| in_gain | output | 4 | Input gain code, 2 dB per step |
| vol_code | output | 7 | Master volume code |
| vol_mute | output | 1 | Volume mute flag |
| spk_r_code | output | 7 | Right speaker attenuation code |
| spk_r_mute | output | 1 | Right speaker mute flag |
| spk_l_code | output | 7 | Left speaker attenuation code |
| spk_l_mute | output | 1 | Left speaker mute flag |

## Verification
The block's internal state shows at the ports in two ways. A wrong bit count or a wrong address match is seen at the next ninth clock, as a missing or extra acknowledge. A wrong slot index or a wrong mode flag is seen a few system clocks after the eighth clock falls in a data byte, as a field moving that should not move. The reference model in the bench compares every register output and mute flag on every settled clock, so a mistake in the wrap or the slot-drop logic shows up within one byte. A mistake that only touches unused slots shows up as a change in a neighbouring field.

// File: rtl/audctl_pkg.sv
package audctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 4;
  localparam int ATT_W   = 7;
  localparam int GAIN_W  = 4;
  localparam int ATT_N   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } bus_state_t;

  localparam logic [1:0]        SRC_RST  = 2'b10;
  localparam logic [GAIN_W-1:0] GAIN_RST = 4'hE;
  localparam logic [ATT_W-1:0]  ATT_RST  = 7'h7F;

  localparam logic [IDX_W-1:0] SLOT_SRC  = 4'd0;
  localparam logic [IDX_W-1:0] SLOT_GAIN = 4'd1;

  // slot of attenuator channel i: 0 volume, 1 right speaker, 2 left speaker
  function automatic logic [IDX_W-1:0] att_slot(input int i);
    case (i)
      0:       att_slot = 4'd2;
      1:       att_slot = 4'd6;
      default: att_slot = 4'd7;
    endcase
  endfunction

  // lowest coarse-step value (bits [6:3]) that means mute
  function automatic logic [3:0] att_mute_min(input int i);
    att_mute_min = (i == 0) ? 4'd6 : 4'd10;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff[0] <= 1'b1;
      sda_ff[0] <= 1'b1;
    end else begin
      scl_ff[0] <= scl_in;
      sda_ff[0] <= sda_in;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff[s] <= 1'b1;
          sda_ff[s] <= 1'b1;
        end else begin
          scl_ff[s] <= scl_ff[s-1];
          sda_ff[s] <= sda_ff[s-1];
        end
      end
    end
  endgenerate

  assign scl_now = scl_ff[STAGES-1];
  assign sda_now = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  assign scl_rise  = scl_now && !scl_prev;
  assign scl_fall  = !scl_now && scl_prev;
  assign start_det = scl_now && scl_prev && sda_prev && !sda_now;
  assign stop_det  = scl_now && scl_prev && !sda_prev && sda_now;
  assign sda_lvl   = sda_now;
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import audctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-2:0] wr_data
);
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int INC_BIT = IDX_W;
  localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};

  bus_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_ph;
  logic [IDX_W-1:0]  idx;
  logic              inc;
  logic              receiving;

  assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
      idx      <= '0;
      inc      <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (scl_rise && !ack_ph && receiving) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph   <= 1'b0;
          sda_pull <= 1'b0;
          bitcnt   <= '0;
        end else if (receiving && bitcnt == CNT_W'(BYTE_W)) begin
          bitcnt <= '0;
          case (state)
            ST_ADDR: begin
              if (shreg == WR_ADDR) begin
                ack_ph   <= 1'b1;
                sda_pull <= 1'b1;
                state    <= ST_SUB;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_SUB: begin
              ack_ph   <= 1'b1;
              sda_pull <= 1'b1;
              idx      <= shreg[IDX_W-1:0];
              inc      <= shreg[INC_BIT];
              state    <= ST_DATA;
            end
            default: begin
              ack_ph   <= 1'b1;
              sda_pull <= 1'b1;
              wr_en    <= 1'b1;
              wr_idx   <= idx;
              wr_data  <= shreg[BYTE_W-2:0];
              if (inc) idx <= idx + 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/audctl_reg_bank.sv
module audctl_reg_bank
  import audctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-2:0]          wr_data,
  output logic [1:0]                 src_sel,
  output logic [GAIN_W-1:0]          in_gain,
  output logic [ATT_N-1:0][ATT_W-1:0] att_code,
  output logic [ATT_N-1:0]           att_mute
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= SRC_RST;
      in_gain <= GAIN_RST;
    end else if (wr_en) begin
      if (wr_idx == SLOT_SRC && wr_data[1]) src_sel <= wr_data[1:0];
      if (wr_idx == SLOT_GAIN) in_gain <= wr_data[GAIN_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < ATT_N; g++) begin : g_att
      localparam logic [IDX_W-1:0] SLOT = att_slot(g);
      localparam logic [3:0]       MMIN = att_mute_min(g);
      always_ff @(posedge clk) begin
        if (rst) begin
          att_code[g] <= ATT_RST;
          att_mute[g] <= 1'b1;
        end else if (wr_en && wr_idx == SLOT) begin
          att_code[g] <= wr_data[ATT_W-1:0];
          att_mute[g] <= (wr_data[ATT_W-1:3] >= MMIN);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
  import audctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_low,
  output logic [1:0] src_sel,
  output logic [3:0] in_gain,
  output logic [6:0] vol_code,
  output logic       vol_mute,
  output logic [6:0] spk_r_code,
  output logic       spk_r_mute,
  output logic [6:0] spk_l_code,
  output logic       spk_l_mute
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [BYTE_W-2:0]           wr_data;
  logic [ATT_N-1:0][ATT_W-1:0] att_code;
  logic [ATT_N-1:0]            att_mute;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  twi_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .sda_pull(sda_pull_low), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  audctl_reg_bank u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .src_sel(src_sel), .in_gain(in_gain), .att_code(att_code), .att_mute(att_mute)
  );

  assign vol_code   = att_code[0];
  assign vol_mute   = att_mute[0];
  assign spk_r_code = att_code[1];
  assign spk_r_mute = att_mute[1];
  assign spk_l_code = att_code[2];
  assign spk_l_mute = att_mute[2];
endmodule

// File: rtl/audctl_checker.sv
module audctl_checker (
  input logic       clk,
  input logic       rst,
  input logic       sda_pull_low,
  input logic [1:0] src_sel,
  input logic [3:0] in_gain,
  input logic [6:0] vol_code,
  input logic       vol_mute,
  input logic [6:0] spk_r_code,
  input logic       spk_r_mute,
  input logic [6:0] spk_l_code,
  input logic       spk_l_mute
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (src_sel == 2'b10 && in_gain == 4'hE && vol_mute && spk_r_mute && spk_l_mute));

  assert_src_valid_R8: assert property (@(posedge clk) disable iff (rst)
    src_sel[1] == 1'b1);

  assert_vol_mute_R10: assert property (@(posedge clk) disable iff (rst)
    vol_mute == (vol_code[6:3] >= 4'd6));

  assert_spk_r_mute_R10: assert property (@(posedge clk) disable iff (rst)
    spk_r_mute == (spk_r_code[6:3] >= 4'd10));

  assert_spk_l_mute_R10: assert property (@(posedge clk) disable iff (rst)
    spk_l_mute == (spk_l_code[6:3] >= 4'd10));

  assert_write_acked_R2: assert property (@(posedge clk) disable iff (rst)
    !($stable(vol_code) && $stable(spk_r_code) && $stable(spk_l_code) &&
      $stable(in_gain) && $stable(src_sel)) |-> sda_pull_low);
endmodule

bind audio_ctrl_i2c_slave audctl_checker u_chk (
  .clk(clk), .rst(rst), .sda_pull_low(sda_pull_low),
  .src_sel(src_sel), .in_gain(in_gain),
  .vol_code(vol_code), .vol_mute(vol_mute),
  .spk_r_code(spk_r_code), .spk_r_mute(spk_r_mute),
  .spk_l_code(spk_l_code), .spk_l_mute(spk_l_mute)
);

// File: tb/audio_ctrl_i2c_slave_test.sv
`timescale 1ns/1ps
module audio_ctrl_i2c_slave_test;
  localparam int H = 20;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, vol_mute, spk_r_mute, spk_l_mute;
  logic [1:0] src_sel;
  logic [3:0] in_gain;
  logic [6:0] vol_code, spk_r_code, spk_l_code;
  wire sda_bus = sda_m & ~sda_pull_low;

  int n_cmp = 0, n_bad = 0, cyc = 0, last_edge = 0;
  logic [1:0] e_src = 2'b10;
  logic [3:0] e_gain = 4'hE;
  logic [6:0] e_vol = 7'h7F, e_spr = 7'h7F, e_spl = 7'h7F;
  logic [7:0] tx [0:15];
  int tx_n;

  always #4 clk = ~clk;

  audio_ctrl_i2c_slave uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .src_sel(src_sel), .in_gain(in_gain),
    .vol_code(vol_code), .vol_mute(vol_mute), .spk_r_code(spk_r_code),
    .spk_r_mute(spk_r_mute), .spk_l_code(spk_l_code), .spk_l_mute(spk_l_mute));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model compared on every settled clock
  always @(negedge clk) begin
    if (!rst && (cyc - last_edge) > 8) begin
      chk("R8 src_sel", src_sel, e_src);
      chk("R9 in_gain", in_gain, e_gain);
      chk("R5 vol_code", vol_code, e_vol);
      chk("R6 spk_r_code", spk_r_code, e_spr);
      chk("R6 spk_l_code", spk_l_code, e_spl);
      chk("R10 vol_mute", vol_mute, (e_vol[6:3] >= 6) ? 1 : 0);
      chk("R10 spk_r_mute", spk_r_mute, (e_spr[6:3] >= 10) ? 1 : 0);
      chk("R10 spk_l_mute", spk_l_mute, (e_spl[6:3] >= 10) ? 1 : 0);
    end
  end

  task automatic model_write(input int slot, input logic [7:0] d);
    case (slot)
      0: if (d[1]) e_src = d[1:0];
      1: e_gain = d[3:0];
      2: e_vol = d[6:0];
      6: e_spr = d[6:0];
      7: e_spl = d[6:0];
      default: ;
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_scl(input logic v);
    @(posedge clk); #1; scl_m = v; last_edge = cyc;
  endtask

  task automatic set_sda(input logic v);
    @(posedge clk); #1; sda_m = v; last_edge = cyc;
  endtask

  task automatic bus_start();
    set_sda(1'b1); wait_clk(H/2);
    if (!scl_m) set_scl(1'b1);
    wait_clk(H/2);
    set_sda(1'b0); wait_clk(H/2);
    set_scl(1'b0); wait_clk(H/2);
  endtask

  task automatic bus_stop();
    set_sda(1'b0); wait_clk(H/2);
    set_scl(1'b1); wait_clk(H/2);
    set_sda(1'b1); wait_clk(H);
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic exp_ack, input int slot);
    for (int i = 7; i >= 0; i--) begin
      set_sda(b[i]); wait_clk(H/2);
      set_scl(1'b1); wait_clk(H);
      set_scl(1'b0);
    end
    if (slot >= 0) model_write(slot, b);
    wait_clk(H/2);
    set_sda(1'b1); wait_clk(H/2);
    set_scl(1'b1); wait_clk(H/2);
    chk(exp_ack ? "R2 ack present" : "R3 ack absent", sda_pull_low, exp_ack);
    wait_clk(H/2);
    set_scl(1'b0); wait_clk(H/2);
  endtask

  task automatic txn(input bit do_stop);
    logic match;
    int slot;
    logic inc;
    match = (tx[0] == 8'h88);
    bus_start();
    bus_byte(tx[0], match, -1);
    slot = 0; inc = 1'b0;
    for (int k = 1; k < tx_n; k++) begin
      if (!match) bus_byte(tx[k], 1'b0, -1);
      else if (k == 1) begin
        slot = tx[1][3:0]; inc = tx[1][4];
        bus_byte(tx[k], 1'b1, -1);
      end else begin
        bus_byte(tx[k], 1'b1, slot);
        if (inc) slot = (slot + 1) % 16;
      end
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    wait_clk(5);
    @(posedge clk); #1; rst = 1'b0;
    wait_clk(12);
    // R1 reset state
    chk("R1 src", src_sel, 2'b10);
    chk("R1 gain", in_gain, 4'hE);
    chk("R1 mutes", {vol_mute, spk_r_mute, spk_l_mute}, 3'b111);
    chk("R1 vol", vol_code, 7'h7F);

    // R5 same slot, last wins
    tx[0]=8'h88; tx[1]=8'h02; tx[2]=8'h15; tx[3]=8'h33; tx_n=4; txn(1);
    chk("R5 vol last byte", vol_code, 7'h33);

    // R6 and R7 increment through all eight slots
    tx[0]=8'h88; tx[1]=8'h10; tx[2]=8'h03; tx[3]=8'h07; tx[4]=8'h20;
    tx[5]=8'hAA; tx[6]=8'hBB; tx[7]=8'hCC; tx[8]=8'h11; tx[9]=8'h12; tx_n=10; txn(1);
    chk("R8 src first input", src_sel, 2'b11);
    chk("R7 vol after unused slots", vol_code, 7'h20);
    chk("R6 spk_l", spk_l_code, 7'h12);

    // R6 drop slots 8..15, wrap to 0; R8 code 01 ignored
    tx[0]=8'h88; tx[1]=8'h16; tx[2]=8'h40; tx[3]=8'h41;
    for (int k = 4; k < 12; k++) tx[k] = 8'h00;
    tx[12]=8'h01; tx[13]=8'h3C; tx_n=14; txn(1);
    chk("R6 wrapped gain", in_gain, 4'hC);
    chk("R6 dropped slots keep src", src_sel, 2'b11);
    chk("R6 spk_r", spk_r_code, 7'h40);

    // R3 wrong addresses
    tx[0]=8'h89; tx[1]=8'h02; tx[2]=8'h00; tx_n=3; txn(1);
    tx[0]=8'h90; tx[1]=8'h02; tx[2]=8'h00; tx_n=3; txn(1);
    chk("R3 vol untouched", vol_code, 7'h20);

    // R11 repeated START
    tx[0]=8'h88; tx[1]=8'h12; tx[2]=8'h05; tx_n=3; txn(0);
    tx[0]=8'h88; tx[1]=8'h07; tx[2]=8'h50; tx_n=3; txn(1);
    chk("R11 vol", vol_code, 7'h05);
    chk("R11 spk_l", spk_l_code, 7'h50);

    // R4 upper subaddress bits, R9 bit 7 ignored
    tx[0]=8'h88; tx[1]=8'hE2; tx[2]=8'h31; tx[3]=8'hB2; tx_n=4; txn(1);
    chk("R4 R9 vol", vol_code, 7'h32);

    // R10 mute thresholds
    tx[0]=8'h88; tx[1]=8'h12; tx[2]=8'h2F; tx[3]=8'h00; tx[4]=8'h00; tx[5]=8'h00;
    tx[6]=8'h4F; tx[7]=8'h50; tx_n=8; txn(1);
    chk("R10 vol below", vol_mute, 0);
    chk("R10 spk_r below", spk_r_mute, 0);
    chk("R10 spk_l at limit", spk_l_mute, 1);
    tx[0]=8'h88; tx[1]=8'h02; tx[2]=8'h30; tx_n=3; txn(1);
    chk("R10 vol at limit", vol_mute, 1);

    // R8 code 00 ignored, 10 accepted
    tx[0]=8'h88; tx[1]=8'h00; tx[2]=8'h00; tx_n=3; txn(1);
    chk("R8 src kept", src_sel, 2'b11);
    tx[0]=8'h88; tx[1]=8'h00; tx[2]=8'h02; tx_n=3; txn(1);
    chk("R8 src second input", src_sel, 2'b10);

    wait_clk(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule